// File: doc/BRIEF.md
# Hop-Field Path Skipper

This block sits in a streaming header parser. It watches a 64-bit packet stream and locates the end of a variable-length list of 8-byte hop-field records. Each record fills exactly one beat. The block never decodes, stores or rewrites these records. The stream passes straight through, and a one-beat sideband pulse marks the first beat after the path, which is where the next header begins. The same pulse carries a class for that next header (IPv4, IPv6 or other), taken from a type code.

A packet consists of `HDR_BEATS` fixed-header beats, then N path beats, then the remaining beats. The hop-field count N and the type code are sampled together with beat 0. The skip is split into two stages. The coarse stage jumps in whole groups of 8 beats, N[7:3] groups. The fine stage then jumps the remaining N[2:0] beats. Each stage therefore picks one of a small fixed set of lengths, and no single variable-length comparison is needed.

The state machine has six states:
- `ST_IDLE` waits for beat 0.
- `ST_HDR` counts the remaining fixed-header beats.
- `ST_COARSE` walks the groups.
- `ST_FINE` walks the leftover beats.
- `ST_NEXT` expects the beat just past the path.
- `ST_TAIL` passes the rest of the packet.

Its transitions are:
- **start**: `ST_IDLE` to `ST_HDR`, or directly into the path states when the fixed header is one beat long.
- **route**: the end of the header enters `ST_COARSE` if N[7:3] is non-zero, `ST_FINE` if only N[2:0] is non-zero, and `ST_NEXT` if N is 0.
- **group-end**: `ST_COARSE` to `ST_FINE` or `ST_NEXT`.
- **fine-end**: `ST_FINE` to `ST_NEXT`.
- **found**: `ST_NEXT` to `ST_TAIL`.
- **overlong**: `ST_IDLE` to `ST_TAIL`.
- **close**: any state returns to `ST_IDLE` on an accepted `last`.

Top module: `hop_path_skipper`

## Requirements
- R1: `m_data`, `m_valid` and `m_last` equal `s_data`, `s_valid` and `s_last` in every cycle, and `s_ready` equals `m_ready`. No beat is altered.
- R2: A beat is accepted only in a cycle with `s_valid` and `m_ready` both high. Stalled cycles do not advance the path position, so each beat is counted exactly once.
- R3: For N in 1..64, `path_end` is high exactly on the accepted beat with index `HDR_BEATS`+N, counting beat 0 as the first beat. It is high on no other beat of that packet.
- R4: The skip covers N[7:3] groups of 8 beats followed by N[2:0] single beats. Counts 7, 8, 9, 15, 16, 63 and 64 all end at index `HDR_BEATS`+N.
- R5: With N = 0, `path_end` is high on the accepted beat with index `HDR_BEATS`.
- R6: While `path_end` is high, `nh_sel` is 2'b01 if the type code sampled at beat 0 was 8'h04, 2'b10 if it was 8'h29, and 2'b11 otherwise. While `path_end` is low, `nh_sel` is 2'b00.
- R7: If N > 64, `err_len` is high on beat 0. No `path_end` occurs for that packet, and the packet still passes through.
- R8: If `last` is accepted on a beat with index below `HDR_BEATS`+N (with N ≤ 64), `err_trunc` is high on that beat and no `path_end` occurs. The next packet is handled from its own beat 0.
- R9: At most one of `path_end`, `err_len` and `err_trunc` is high at a time. All three are low in any cycle without an accepted beat, including directly after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_data | input | 64 | Input stream data |
| s_valid | input | 1 | Input beat valid |
| s_last | input | 1 | Input beat is last of packet |
| s_ready | output | 1 | Input ready (follows m_ready) |
| hop_count | input | 8 | Hop-field count N, sampled on beat 0 |
| next_type | input | 8 | Next-header type code, sampled on beat 0 |
| m_data | output | 64 | Output stream data |
| m_valid | output | 1 | Output beat valid |
| m_last | output | 1 | Output last |
| m_ready | input | 1 | Downstream ready |
| path_end | output | 1 | Pulse on the first accepted beat after the path |
| nh_sel | output | 2 | Next-header class during path_end |
| err_len | output | 1 | Pulse: hop count above 64 |
| err_trunc | output | 1 | Pulse: packet ended before the path did |

## Verification
The embedded properties check several things on every cycle:
- The sideband pulses are mutually exclusive.
- `path_end` never lasts two cycles and always carries a real class.
- A stalled cycle freezes the state and all skip counters.
- The coarse group counter stays within the 64-hop bound.
- An overlong count sends the machine past the path states.

Only the bench scenarios can show that the pulse lands on exactly the right beat index under random stalls for each count from 0 to 64. They also show the truncation and length-error cases, and that packets after an error start cleanly.

// File: rtl/hps_pkg.sv
package hps_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_HDR    = 3'd1,
        ST_COARSE = 3'd2,
        ST_FINE   = 3'd3,
        ST_NEXT   = 3'd4,
        ST_TAIL   = 3'd5
    } hps_state_e;

    typedef enum logic [1:0] {
        NH_NONE  = 2'b00,
        NH_V4    = 2'b01,
        NH_V6    = 2'b10,
        NH_OTHER = 2'b11
    } nh_class_e;

endpackage

// File: rtl/hps_nh_classify.sv
module hps_nh_classify
    import hps_pkg::*;
#(
    parameter int          TYPE_W  = 8,
    parameter logic [7:0]  V4_CODE = 8'h04,
    parameter logic [7:0]  V6_CODE = 8'h29
) (
    input  logic [TYPE_W-1:0] code,
    output nh_class_e         cls
);

    always_comb begin
        if (code == TYPE_W'(V4_CODE))      cls = NH_V4;
        else if (code == TYPE_W'(V6_CODE)) cls = NH_V6;
        else                               cls = NH_OTHER;
    end

endmodule

// File: rtl/hop_path_skipper.sv
module hop_path_skipper
    import hps_pkg::*;
#(
    parameter int         DATA_W    = 64,
    parameter int         CNT_W     = 8,
    parameter int         TYPE_W    = 8,
    parameter int         HDR_BEATS = 2,
    parameter int         MAX_HOPS  = 64,
    parameter int         GROUP     = 8,
    parameter logic [7:0] V4_CODE   = 8'h04,
    parameter logic [7:0] V6_CODE   = 8'h29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_valid,
    input  logic              s_last,
    output logic              s_ready,
    input  logic [CNT_W-1:0]  hop_count,
    input  logic [TYPE_W-1:0] next_type,
    output logic [DATA_W-1:0] m_data,
    output logic              m_valid,
    output logic              m_last,
    input  logic              m_ready,
    output logic              path_end,
    output logic [1:0]        nh_sel,
    output logic              err_len,
    output logic              err_trunc
);

    localparam int FINE_W = $clog2(GROUP);
    localparam int GRP_W  = CNT_W - FINE_W;
    localparam int HDR_W  = (HDR_BEATS > 1) ? $clog2(HDR_BEATS) : 1;

    hps_state_e          state_q, state_d;
    logic [HDR_W-1:0]    hdr_q, hdr_d;
    logic [GRP_W-1:0]    grp_q, grp_d;
    logic [FINE_W-1:0]   sub_q, sub_d;
    logic [FINE_W-1:0]   fine_q, fine_d;
    logic [CNT_W-1:0]    cnt_q, cnt_d;
    logic [TYPE_W-1:0]   type_q, type_d;

    logic                fire;
    logic                too_long;
    logic [CNT_W-1:0]    cnt_src;
    logic [GRP_W-1:0]    coarse_src;
    logic [FINE_W-1:0]   fine_src;
    hps_state_e          r_state;
    logic [GRP_W-1:0]    r_grp;
    logic [FINE_W-1:0]   r_sub;
    logic [FINE_W-1:0]   r_fine;
    nh_class_e           cls;

    // Stream passes through untouched
    assign m_data  = s_data;
    assign m_valid = s_valid;
    assign m_last  = s_last;
    assign s_ready = m_ready;

    assign fire     = s_valid && m_ready;
    assign too_long = hop_count > CNT_W'(MAX_HOPS);

    // Route choice at the end of the fixed header: coarse, fine or none
    assign cnt_src    = (state_q == ST_IDLE) ? hop_count : cnt_q;
    assign coarse_src = cnt_src[CNT_W-1:FINE_W];
    assign fine_src   = cnt_src[FINE_W-1:0];

    always_comb begin
        r_grp  = grp_q;
        r_sub  = sub_q;
        r_fine = fine_q;
        if (coarse_src != '0) begin
            r_state = ST_COARSE;
            r_grp   = coarse_src - GRP_W'(1);
            r_sub   = FINE_W'(GROUP - 1);
        end else if (fine_src != '0) begin
            r_state = ST_FINE;
            r_fine  = fine_src - FINE_W'(1);
        end else begin
            r_state = ST_NEXT;
        end
    end

    hps_nh_classify #(
        .TYPE_W  (TYPE_W),
        .V4_CODE (V4_CODE),
        .V6_CODE (V6_CODE)
    ) u_cls (
        .code (type_q),
        .cls  (cls)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        hdr_d   = hdr_q;
        grp_d   = grp_q;
        sub_d   = sub_q;
        fine_d  = fine_q;
        cnt_d   = cnt_q;
        type_d  = type_q;
        unique case (state_q)
            ST_IDLE: if (fire) begin
                cnt_d  = hop_count;
                type_d = next_type;
                if (too_long) begin
                    state_d = s_last ? ST_IDLE : ST_TAIL;
                end else if (s_last) begin
                    state_d = ST_IDLE;
                end else if (HDR_BEATS > 1) begin
                    state_d = ST_HDR;
                    hdr_d   = HDR_W'(HDR_BEATS - 2);
                end else begin
                    state_d = r_state;
                    grp_d   = r_grp;
                    sub_d   = r_sub;
                    fine_d  = r_fine;
                end
            end
            ST_HDR: if (fire) begin
                if (s_last) begin
                    state_d = ST_IDLE;
                end else if (hdr_q == '0) begin
                    state_d = r_state;
                    grp_d   = r_grp;
                    sub_d   = r_sub;
                    fine_d  = r_fine;
                end else begin
                    hdr_d = hdr_q - HDR_W'(1);
                end
            end
            ST_COARSE: if (fire) begin
                if (s_last) begin
                    state_d = ST_IDLE;
                end else if (sub_q != '0) begin
                    sub_d = sub_q - FINE_W'(1);
                end else if (grp_q != '0) begin
                    grp_d = grp_q - GRP_W'(1);
                    sub_d = FINE_W'(GROUP - 1);
                end else if (cnt_q[FINE_W-1:0] != '0) begin
                    state_d = ST_FINE;
                    fine_d  = cnt_q[FINE_W-1:0] - FINE_W'(1);
                end else begin
                    state_d = ST_NEXT;
                end
            end
            ST_FINE: if (fire) begin
                if (s_last)              state_d = ST_IDLE;
                else if (fine_q != '0)   fine_d  = fine_q - FINE_W'(1);
                else                     state_d = ST_NEXT;
            end
            ST_NEXT: if (fire) begin
                state_d = s_last ? ST_IDLE : ST_TAIL;
            end
            ST_TAIL: if (fire && s_last) begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hdr_q   <= '0;
            grp_q   <= '0;
            sub_q   <= '0;
            fine_q  <= '0;
            cnt_q   <= '0;
            type_q  <= '0;
        end else begin
            state_q <= state_d;
            hdr_q   <= hdr_d;
            grp_q   <= grp_d;
            sub_q   <= sub_d;
            fine_q  <= fine_d;
            cnt_q   <= cnt_d;
            type_q  <= type_d;
        end
    end

    // Sideband outputs
    always_comb begin
        path_end  = fire && (state_q == ST_NEXT);
        nh_sel    = path_end ? cls : NH_NONE;
        err_len   = fire && (state_q == ST_IDLE) && too_long;
        err_trunc = fire && s_last &&
                    (((state_q == ST_IDLE) && !too_long) ||
                     (state_q == ST_HDR) || (state_q == ST_COARSE) ||
                     (state_q == ST_FINE));
    end

    AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        path_end |=> !path_end) else $error("path_end held"); // R3

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_valid && m_ready) |=> ($stable(state_q) && $stable(grp_q) &&
                                   $stable(sub_q) && $stable(fine_q)))
        else $error("state moved on stall"); // R2

    AST_GRP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COARSE) |-> (grp_q < GRP_W'(MAX_HOPS / GROUP)))
        else $error("group counter out of range"); // R4

    AST_CLASS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        path_end |-> (nh_sel != NH_NONE)) else $error("empty class"); // R6

    AST_LEN_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
        err_len |=> (state_q == ST_TAIL || state_q == ST_IDLE))
        else $error("overlong entered path"); // R7

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({path_end, err_len, err_trunc}))
        else $error("pulses overlap"); // R9

endmodule

// File: tb/tb_hop_path_skipper.sv
`timescale 1ns/1ps
module tb_hop_path_skipper;

    localparam int F = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] s_data = '0;
    logic        s_valid = 1'b0;
    logic        s_last = 1'b0;
    logic        s_ready;
    logic [7:0]  hop_count = '0;
    logic [7:0]  next_type = '0;
    logic [63:0] m_data;
    logic        m_valid;
    logic        m_last;
    logic        m_ready = 1'b0;
    logic        path_end;
    logic [1:0]  nh_sel;
    logic        err_len;
    logic        err_trunc;

    int tests = 0;
    int fails = 0;
    int seq   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    hop_path_skipper #(.HDR_BEATS(F)) dut (
        .clk(clk), .rst_n(rst_n),
        .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
        .hop_count(hop_count), .next_type(next_type),
        .m_data(m_data), .m_valid(m_valid), .m_last(m_last), .m_ready(m_ready),
        .path_end(path_end), .nh_sel(nh_sel),
        .err_len(err_len), .err_trunc(err_trunc)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] cls_of(input logic [7:0] t);
        if (t == 8'h04) return 2'b01;
        if (t == 8'h29) return 2'b10;
        return 2'b11;
    endfunction

    // Behavioural reference: beat index b counts only accepted beats
    task automatic compare(input int b, input int n, input logic [7:0] ty);
        bit fire, pe, el, tr;
        fire = s_valid && m_ready;
        pe = fire && n <= 64 && b == F + n;
        el = fire && b == 0 && n > 64;
        tr = fire && n <= 64 && s_last && b < F + n;
        chk("R1 data", m_data, s_data);
        chk("R1 ctrl", {m_valid, m_last, s_ready}, {s_valid, s_last, m_ready});
        if (n == 0) chk("R5 path_end", path_end, pe);
        else        chk("R3 R4 R2 path_end", path_end, pe);
        chk("R6 nh_sel", nh_sel, pe ? cls_of(ty) : 2'b00);
        chk("R7 err_len", err_len, el);
        chk("R8 err_trunc", err_trunc, tr);
        chk("R9 exclusive", {63'd0, (path_end + err_len + err_trunc) > 1}, 64'd0);
    endtask

    task automatic run_pkt(input int n, input logic [7:0] ty, input int len, input int stall);
        for (int b = 0; b < len; b++) begin
            bit done = 0;
            while (!done) begin
                @(negedge clk);
                s_valid   = ($urandom % 100) >= stall;
                m_ready   = ($urandom % 100) >= stall;
                seq++;
                s_data    = {32'(b), 32'(seq)};
                s_last    = (b == len - 1);
                hop_count = (b == 0) ? 8'(n) : 8'($urandom);
                next_type = (b == 0) ? ty : 8'($urandom);
                #1;
                compare(b, n, ty);
                if (s_valid && m_ready) done = 1;
            end
        end
        @(negedge clk);
        s_valid = 1'b0;
        m_ready = 1'b1;
        #1;
        chk("R9 quiet", {path_end, err_len, err_trunc}, 3'b000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R9 reset", {path_end, err_len, err_trunc, nh_sel}, 5'b0);

        // R5 zero-length path
        run_pkt(0, 8'h04, F + 3, 0);
        run_pkt(0, 8'h29, F + 1, 30);
        // R3 / R4 group boundaries, R6 classes
        run_pkt(1, 8'h29, F + 4, 0);
        run_pkt(7, 8'h04, F + 9, 20);
        run_pkt(8, 8'h11, F + 10, 0);
        run_pkt(9, 8'h29, F + 11, 40);
        run_pkt(15, 8'h04, F + 17, 10);
        run_pkt(16, 8'h29, F + 18, 50);
        run_pkt(63, 8'h04, F + 66, 25);
        run_pkt(64, 8'h29, F + 65, 0);
        run_pkt(64, 8'h06, F + 70, 35);
        for (int n = 0; n <= 64; n++) run_pkt(n, (n % 2) ? 8'h04 : 8'h29, F + n + 2, 30);
        // R7 overlong counts
        run_pkt(65, 8'h04, 4, 20);
        run_pkt(200, 8'h29, 1, 0);
        run_pkt(3, 8'h04, F + 5, 0);
        // R8 truncation, including last on final path beat and single beat
        run_pkt(10, 8'h04, 5, 20);
        run_pkt(10, 8'h04, F + 10, 0);
        run_pkt(0, 8'h29, 1, 0);
        run_pkt(20, 8'h29, 2, 30);
        run_pkt(10, 8'h04, F + 11, 0);
        run_pkt(5, 8'h29, F + 7, 45);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule